// File: doc/BRIEF.md
# Three-wire-plus-select serial EEPROM command controller

This block lets a host run single-word commands on a small serial EEPROM with four wires: a select line, a shift clock, a data line to the device and a data line from it. The host presents one command (read one word, write one word, unlock writes or lock writes), a word address and, for a write, a 16-bit value. The block then produces the whole serial exchange from a divided system clock, and it reports completion with a one-cycle done pulse. A read returns its word on the same pulse.

The device address can be 6 or 8 bits. An input picks the width for each command. The unlock and lock commands are padded with zeros to the chosen width. After a write, the block briefly drops select, raises it again and keeps clocking until the device signals that its internal programming is over. If that never happens within a set number of clocks, the block flags an error and finishes anyway. Multi-word transfers are built by the host as repeated commands. A write session is meant to be unlock, then the writes, then lock, so the device is left protected.

Top module: `uw_eeprom_ctrl`

## Requirements
- R1: A command is accepted on a clock where `cmd_valid_i` is high and `busy_o` is low. `busy_o` is high from the next clock until the clock of `done_o`. A `cmd_valid_i` seen while `busy_o` is high starts no frame.
- R2: Each command first raises `cs_o` for one shift-clock period with `do_o` low. It then shifts out a start bit of 1. Every field goes out most significant bit first.
- R3: Read (`cmd_i`=0) sends 1,1,0 and then the address. It then clocks in 17 bits. The first of these is a dummy that is dropped, and the remaining 16 appear on `rdata_o` with `done_o`, held until the next read completes.
- R4: Write (`cmd_i`=1) sends 1,0,1, then the address, then the 16 data bits.
- R5: Unlock (`cmd_i`=2) sends 1,0,0,1,1 and then zeros. Lock (`cmd_i`=3) sends 1,0,0 and then zeros. The frame is 9 bits long in 6-bit mode and 11 bits long in 8-bit mode.
- R6: With `wide_addr_i`=1 the address field is `addr_i[7:0]`. With `wide_addr_i`=0 it is `addr_i[5:0]`, and bits 7:6 have no effect.
- R7: After the last write data bit, `cs_o` goes low for one shift period with no clock pulse. It then goes high again, and the block keeps clocking until `di_i` is sampled as 1.
- R8: If `di_i` has not been sampled as 1 after POLL_MAX poll periods, `err_o` goes high and the command still completes. `err_o` is cleared when the next command is accepted.
- R9: Every command ends with `cs_o` low and exactly one full clock pulse before `done_o`.
- R10: `do_o` does not change while `sk_o` is high. `di_i` is sampled at the end of the high phase. Each phase lasts HALF_DIV system clocks.
- R11: After reset, `cs_o`, `sk_o`, `do_o`, `busy_o`, `done_o` and `err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 2 | 0 read, 1 write, 2 unlock, 3 lock |
| addr_i | input | 8 | Word address |
| wdata_i | input | 16 | Write data |
| wide_addr_i | input | 1 | 1: 8-bit address, 0: 6-bit address |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last word read |
| err_o | output | 1 | Ready-poll timeout on the last command |
| cs_o | output | 1 | Device select |
| sk_o | output | 1 | Shift clock |
| do_o | output | 1 | Serial data to device |
| di_i | input | 1 | Serial data from device |

## Verification
A wrong bit counter or frame image shows at the device side within the same command. The frame length and contents captured by the device model differ, or the read word is off by one bit position because the dummy bit was kept or an extra bit was dropped. A wrong sequencer state shows up as a missing or doubled closing clock pulse, or a poll that never ends, well before `done_o`. A stale error flag shows on the very next completion pulse. Random mixes of commands and address widths against a shadow memory expose ordering slips, and any corrupted write surfaces at the next read of that word.

// File: rtl/uw_pkg.sv
package uw_pkg;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = 3 + 8 + WORD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_WREN  = 2'd2,
        CMD_WRDIS = 2'd3
    } uw_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSPULSE,
        ST_SHIFT,
        ST_RECV,
        ST_GAP,
        ST_POLL,
        ST_FINAL
    } uw_state_e;
endpackage

// File: rtl/uw_clk_div.sv
module uw_clk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF_DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i)     cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = en_i && wrap;

    // R10
    tick_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> $past(en_i));
endmodule

// File: rtl/uw_rx_shift.sv
module uw_rx_shift
    import uw_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              shift_i,
    input  logic              latch_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sh_d, sh_q, word_d, word_q;

    always_comb begin
        sh_d   = sh_q;
        word_d = word_q;
        if (shift_i) sh_d = {sh_q[WORD_W-2:0], bit_i};
        if (latch_i) word_d = sh_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q   <= '0;
            word_q <= '0;
        end else begin
            sh_q   <= sh_d;
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

    // R3
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(latch_i) |-> $stable(word_q));
endmodule

// File: rtl/uw_eeprom_ctrl.sv
module uw_eeprom_ctrl
    import uw_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int POLL_MAX = 1000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cmd_valid_i,
    input  logic [1:0]  cmd_i,
    input  logic [7:0]  addr_i,
    input  logic [15:0] wdata_i,
    input  logic        wide_addr_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        err_o,
    output logic        cs_o,
    output logic        sk_o,
    output logic        do_o,
    input  logic        di_i
);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    typedef struct packed {
        uw_state_e          state;
        logic               ph;
        logic               cs;
        logic               sk;
        logic               dout;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   bitcnt;
        uw_cmd_e            cmd;
        logic [POLL_W-1:0]  pcnt;
        logic               done;
        logic               err;
    } regs_t;

    regs_t q, d;
    logic  tick, rx_shift, rx_latch;

    logic [1:0]         op_ld;
    logic [7:0]         field_ld;
    logic [WORD_W-1:0]  data_ld;
    logic [FRAME_W-1:0] frame_ld;
    logic [CNT_W-1:0]   len_ld;

    uw_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (q.state != ST_IDLE),
        .tick_o(tick)
    );

    uw_rx_shift u_rx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .shift_i(rx_shift),
        .latch_i(rx_latch),
        .bit_i  (di_i),
        .word_o (rdata_o)
    );

    // Frame image, left aligned: start bit, opcode, address field, data.
    always_comb begin
        data_ld  = '0;
        field_ld = wide_addr_i ? addr_i : {addr_i[5:0], 2'b00};
        unique case (uw_cmd_e'(cmd_i))
            CMD_READ:  op_ld = 2'b10;
            CMD_WRITE: begin op_ld = 2'b01; data_ld = wdata_i; end
            CMD_WREN:  begin op_ld = 2'b00; field_ld = 8'b1100_0000; end
            default:   begin op_ld = 2'b00; field_ld = 8'h00; end
        endcase
        frame_ld = wide_addr_i ? {1'b1, op_ld, field_ld, data_ld}
                               : {1'b1, op_ld, field_ld[7:2], data_ld, 2'b00};
        len_ld = CNT_W'(3) + (wide_addr_i ? CNT_W'(8) : CNT_W'(6))
               + ((uw_cmd_e'(cmd_i) == CMD_WRITE) ? CNT_W'(WORD_W) : CNT_W'(0));
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        rx_shift = 1'b0;
        rx_latch = 1'b0;
        if (q.state == ST_IDLE) begin
            if (cmd_valid_i) begin
                d.state  = ST_CSPULSE;
                d.ph     = 1'b0;
                d.cs     = 1'b1;
                d.sk     = 1'b0;
                d.dout   = 1'b0;
                d.frame  = frame_ld;
                d.bitcnt = len_ld - 1'b1;
                d.cmd    = uw_cmd_e'(cmd_i);
                d.pcnt   = '0;
                d.err    = 1'b0;
            end
        end else if (tick) begin
            if (!q.ph) begin
                d.ph = 1'b1;
                if (q.state != ST_GAP) d.sk = 1'b1;
            end else begin
                d.ph = 1'b0;
                d.sk = 1'b0;
                unique case (q.state)
                    ST_CSPULSE: begin
                        d.state = ST_SHIFT;
                        d.dout  = q.frame[FRAME_W-1];
                    end
                    ST_SHIFT: begin
                        if (q.bitcnt == '0) begin
                            d.dout = 1'b0;
                            unique case (q.cmd)
                                CMD_READ: begin
                                    d.state  = ST_RECV;
                                    d.bitcnt = CNT_W'(WORD_W);
                                end
                                CMD_WRITE: begin
                                    d.state = ST_GAP;
                                    d.cs    = 1'b0;
                                end
                                default: begin
                                    d.state = ST_FINAL;
                                    d.cs    = 1'b0;
                                end
                            endcase
                        end else begin
                            d.frame  = {q.frame[FRAME_W-2:0], 1'b0};
                            d.dout   = q.frame[FRAME_W-2];
                            d.bitcnt = q.bitcnt - 1'b1;
                        end
                    end
                    ST_RECV: begin
                        rx_shift = 1'b1;
                        if (q.bitcnt == '0) begin
                            rx_latch = 1'b1;
                            d.state  = ST_FINAL;
                            d.cs     = 1'b0;
                        end else begin
                            d.bitcnt = q.bitcnt - 1'b1;
                        end
                    end
                    ST_GAP: begin
                        d.state = ST_POLL;
                        d.cs    = 1'b1;
                    end
                    ST_POLL: begin
                        if (di_i) begin
                            d.state = ST_FINAL;
                            d.cs    = 1'b0;
                        end else if (q.pcnt == POLL_W'(POLL_MAX - 1)) begin
                            d.err   = 1'b1;
                            d.state = ST_FINAL;
                            d.cs    = 1'b0;
                        end else begin
                            d.pcnt = q.pcnt + 1'b1;
                        end
                    end
                    ST_FINAL: begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end
                    default: d.state = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state  <= ST_IDLE;
            q.ph     <= 1'b0;
            q.cs     <= 1'b0;
            q.sk     <= 1'b0;
            q.dout   <= 1'b0;
            q.frame  <= '0;
            q.bitcnt <= '0;
            q.cmd    <= CMD_READ;
            q.pcnt   <= '0;
            q.done   <= 1'b0;
            q.err    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.state != ST_IDLE);
    assign done_o = q.done;
    assign err_o  = q.err;
    assign cs_o   = q.cs;
    assign sk_o   = q.sk;
    assign do_o   = q.dout;

    // R10
    dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.sk && $past(q.sk)) |-> $stable(q.dout));

    // R9
    done_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |-> (!q.cs && !q.sk && $past(q.state) == ST_FINAL));

    // R1
    accept_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_CSPULSE && $past(q.state) != ST_CSPULSE) |-> $past(q.state) == ST_IDLE);

    // R8
    err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.err) |-> (q.state == ST_FINAL && $past(q.state) == ST_POLL));

    // R8
    poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.pcnt < POLL_W'(POLL_MAX));

    // R11
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_IDLE) |-> (!q.sk && !q.cs));
endmodule

// File: tb/uw_eeprom_ctrl_tb.sv
module uw_eeprom_ctrl_tb;
    localparam int HALF_DIV = 2;
    localparam int POLL_MAX = 20;
    localparam int BUSY_CLK = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [7:0]  addr = 8'd0;
    logic [15:0] wdata = 16'd0;
    logic        wide = 1'b0;
    logic        busy, done, err, cs, sk, dout, din;
    logic [15:0] rdata;

    always #5 clk = ~clk;

    uw_eeprom_ctrl #(.HALF_DIV(HALF_DIV), .POLL_MAX(POLL_MAX)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
        .addr_i(addr), .wdata_i(wdata), .wide_addr_i(wide), .busy_o(busy),
        .done_o(done), .rdata_o(rdata), .err_o(err), .cs_o(cs), .sk_o(sk),
        .do_o(dout), .di_i(din)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Device model, driven from sampled pin values on the falling system clock.
    logic [15:0] m_mem [256];
    logic [15:0] shadow [256];
    logic        stuck = 1'b0;
    logic        m_din = 1'b1;
    logic        cs_p = 1'b0, sk_p = 1'b0;
    bit          m_started, m_rd, m_poll, m_wen, sh_wen;
    int          m_cnt, m_rdcnt, m_busy, m_frames, last_len, low_pulses;
    logic [31:0] m_sr, last_bits;
    logic [15:0] m_word;
    int          hi_changes = 0;
    logic        dout_p = 1'b0;

    assign din = m_poll ? (m_busy == 0 && !stuck) : m_din;

    function automatic int awidth();
        return wide ? 8 : 6;
    endfunction

    always @(negedge clk) begin
        int aw, a, op;
        aw = awidth();
        if (sk && sk_p && dout != dout_p) hi_changes++;
        dout_p = dout;
        if (cs_p && !cs) begin
            low_pulses = 0;
            if (m_poll) m_poll = 0;
            else begin
                last_len  = m_cnt;
                last_bits = m_sr;
                if (m_started && m_cnt == 19 + aw && ((m_sr >> (aw + 16)) & 3) == 1) begin
                    a = (m_sr >> 16) & ((1 << aw) - 1);
                    if (m_wen) m_mem[a] = m_sr[15:0];
                    m_poll = 1;
                    m_busy = m_wen ? BUSY_CLK : 0;
                end else if (m_started && m_cnt == 3 + aw && ((m_sr >> aw) & 3) == 0) begin
                    op = (m_sr >> (aw - 2)) & 3;
                    if (op == 3) m_wen = 1;
                    if (op == 0) m_wen = 0;
                end
            end
            m_started = 0; m_rd = 0; m_cnt = 0; m_sr = 0; m_din = 1'b1;
        end
        if (sk && !sk_p) begin
            if (!cs) low_pulses++;
            else if (m_poll) begin if (m_busy > 0) m_busy--; end
            else if (m_rd) begin
                m_din = (m_rdcnt == 0) ? 1'b0 : m_word[16 - m_rdcnt];
                m_rdcnt++;
            end else if (!m_started) begin
                if (dout) begin m_started = 1; m_cnt = 1; m_sr = 1; m_frames++; end
            end else begin
                m_sr = {m_sr[30:0], dout};
                m_cnt++;
                if (m_cnt == 3 + aw && ((m_sr >> aw) & 3) == 2) begin
                    m_rd = 1; m_rdcnt = 0;
                    m_word = m_mem[m_sr & ((1 << aw) - 1)];
                end
            end
        end
        cs_p = cs;
        sk_p = sk;
    end

    function automatic logic [31:0] exp_bits(input int c, input int a, input logic [15:0] dv, input int aw);
        int am;
        am = a & ((1 << aw) - 1);
        case (c)
            0: return (32'd6 << aw) | am;
            1: return (((32'd5 << aw) | am) << 16) | dv;
            2: return (32'd4 << aw) | (32'd3 << (aw - 2));
            default: return 32'd4 << aw;
        endcase
    endfunction

    function automatic int exp_len(input int c, input int aw);
        return 3 + aw + ((c == 1) ? 16 : 0);
    endfunction

    task automatic run_cmd(input int c, input int a, input logic [15:0] dv, input bit exp_err, input bit poke);
        int frames0, aw, am;
        aw = awidth();
        am = a & ((1 << aw) - 1);
        frames0 = m_frames;
        @(negedge clk);
        cmd = c[1:0]; addr = a[7:0]; wdata = dv; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            chk(busy == 1'b1, "R1 busy after accept", {31'd0, busy}, 32'd1);
            repeat (7) @(negedge clk);
            cmd = 2'd3; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R1 busy low at done", {31'd0, busy}, 32'd0);
        chk(m_frames == frames0 + 1, "R1 one frame per command", m_frames, frames0 + 1);
        chk(last_len == exp_len(c, aw), "R5 R6 frame length", last_len, exp_len(c, aw));
        chk(last_bits == exp_bits(c, a, dv, aw), "R2 R4 R5 R6 frame bits", last_bits, exp_bits(c, a, dv, aw));
        chk(low_pulses == 1, "R9 closing pulse", low_pulses, 1);
        chk(err == exp_err, "R7 R8 error flag", {31'd0, err}, {31'd0, exp_err});
        if (c == 0) chk(rdata == shadow[am], "R3 read word", {16'd0, rdata}, {16'd0, shadow[am]});
        if (c == 1 && sh_wen) shadow[am] = dv;
        if (c == 2) sh_wen = 1;
        if (c == 3) sh_wen = 0;
        @(negedge clk);
        chk(done == 1'b0, "R1 done single cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_mem[i]  = 16'(i * 16'h1357) ^ 16'hA5A5;
            shadow[i] = 16'(i * 16'h1357) ^ 16'hA5A5;
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({cs, sk, dout, busy, done, err} == 6'd0, "R11 reset outputs",
            {26'd0, cs, sk, dout, busy, done, err}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed: narrow mode
        wide = 1'b0;
        run_cmd(1, 8'h05, 16'h1234, 1'b0, 1'b0);   // R4 write while locked, ignored by device
        run_cmd(0, 8'h05, 16'h0, 1'b0, 1'b0);      // R3
        run_cmd(2, 8'h00, 16'h0, 1'b0, 1'b1);      // R5 unlock 9 bits, R1 ignored request
        run_cmd(1, 8'hC5, 16'hBEEF, 1'b0, 1'b0);   // R6 upper bits ignored, R7 poll
        run_cmd(0, 8'h05, 16'h0, 1'b0, 1'b0);      // R3 R6
        run_cmd(1, 8'h3F, 16'h8001, 1'b0, 1'b1);
        run_cmd(0, 8'h3F, 16'h0, 1'b0, 1'b0);
        // Directed: wide mode
        wide = 1'b1;
        run_cmd(2, 8'h00, 16'h0, 1'b0, 1'b0);      // R5 11 bits
        run_cmd(1, 8'hFF, 16'h0000, 1'b0, 1'b0);
        run_cmd(0, 8'hFF, 16'h0, 1'b0, 1'b0);
        run_cmd(0, 8'h3F, 16'h0, 1'b0, 1'b0);      // written in narrow mode
        // R8 timeout
        stuck = 1'b1;
        run_cmd(1, 8'h80, 16'h5A5A, 1'b1, 1'b0);
        stuck = 1'b0;
        run_cmd(0, 8'h80, 16'h0, 1'b0, 1'b0);      // R8 cleared on accept
        run_cmd(3, 8'h00, 16'h0, 1'b0, 1'b0);      // R5 lock
        run_cmd(1, 8'h80, 16'hFFFF, 1'b0, 1'b0);
        run_cmd(0, 8'h80, 16'h0, 1'b0, 1'b0);

        // Random mix
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 150; n++) begin
            int c;
            c = $urandom_range(0, 9);
            c = (c < 4) ? 0 : (c < 8) ? 1 : (c == 8) ? 2 : 3;
            wide = 1'($urandom_range(0, 1));
            run_cmd(c, $urandom_range(0, 255), 16'($urandom), 1'b0, n % 11 == 0);
        end
        chk(hi_changes == 0, "R10 data steady while clock high", hi_changes, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule